// File: doc/BRIEF.md
# Key-Guarded Register Bank

This block holds four 16-bit peripheral registers on a byte-addressed 16-bit bus, together with a write-access lock that is opened by writing a key. The first control register has two roles. Its upper byte is the key port, and its lower byte is ordinary storage. A second control register accepts full-word writes only. A flag register is writable in both byte lanes. A power-mode register is exempt from the lock and can be written at any time.

An illegal access produces a registered, single-cycle reset-request pulse for the system reset logic. The illegal accesses are a guarded write while the bank is locked, and a word write that carries a wrong key. A wrong key written as a single byte does not raise the pulse. It only closes the lock again. The lock state is visible on `write_open`. Reads are combinational and return the whole word that holds the addressed byte.

Top module: `keyguard_regs`

## Requirements
- R1: After reset, the registers read control-0 = 9640h (offset 00h), control-1 = 9600h (offset 02h), flags = 0000h (offset 0Ah) and power-mode = 0001h (offset 10h). After reset, `write_open` is 0 and `reset_req` is 0.
- R2: A byte write of A5h to address 01h opens the lock. A word write to 00h whose bits 15:8 equal A5h also opens the lock, and it stores bits 7:0 into the low byte of control-0.
- R3: A byte write to 01h of any value other than A5h closes the lock and raises no reset request.
- R4: A word write to 00h whose bits 15:8 differ from A5h raises `reset_req` and leaves control-0 unchanged.
- R5: While the lock is closed, any write to addresses 02h, 03h, 0Ah or 0Bh raises `reset_req` and leaves the target register unchanged.
- R6: Writes to the power-mode register at 10h/11h take effect whether the lock is open or closed, and they never raise `reset_req`.
- R7: While the lock is open, a word write to control-1 stores bits 7:0. A byte write to 02h or 03h is ignored and raises no reset request.
- R8: While the lock is open, a byte write to 00h updates the low byte of control-0. While the lock is closed, the same write is ignored and raises no reset request.
- R9: Bits 15:8 of control-0 and of control-1 always read 96h, whatever was written to them.
- R10: Byte lanes work as follows. A byte write to an even address takes `wdata[7:0]` into bits 7:0. A byte write to an odd address takes `wdata[15:8]` into bits 15:8. A word access ignores address bit 0. `rdata` returns the word at `addr` with bit 0 dropped.
- R11: `reset_req` goes high in the cycle after the offending write edge and stays high for exactly one cycle. `write_open` is 0 from the cycle after that. Any write presented while `reset_req` is high is ignored.
- R12: Writes to unmapped addresses change nothing and raise no reset request. Reads from unmapped addresses return 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr | input | 1 | Write strobe, one access per cycle |
| word | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr | input | 5 | Byte address |
| wdata | input | 16 | Write data, with bytes on their natural lanes |
| rdata | output | 16 | Word containing the addressed byte |
| write_open | output | 1 | Lock state, 1 = guarded writes allowed |
| reset_req | output | 1 | Single-cycle system reset request |

## Verification
The assertions assume that `wr`, `word`, `addr` and `wdata` are stable across each rising edge. They also assume that byte data arrives on the lane selected by address bit 0, so that the key is always taken from `wdata[15:8]`. The stimulus meets both conditions by changing the inputs only on falling edges. It also places every byte value on its proper lane, including during the cycle in which `reset_req` is high, when the write is expected to be discarded.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = WORD_W / BYTE_W;

  localparam logic [BYTE_W-1:0] UNLOCK_KEY = 8'hA5;
  localparam logic [BYTE_W-1:0] HI_READ    = 8'h96;

  localparam int unsigned OFS_CTRL0 = 'h00;
  localparam int unsigned OFS_CTRL1 = 'h02;
  localparam int unsigned OFS_FLAGS = 'h0A;
  localparam int unsigned OFS_PMODE = 'h10;

  localparam logic [BYTE_W-1:0] INIT_CTRL0_LO = 8'h40;
  localparam logic [BYTE_W-1:0] INIT_CTRL1_LO = 8'h00;
  localparam logic [WORD_W-1:0] INIT_FLAGS    = 16'h0000;
  localparam logic [WORD_W-1:0] INIT_PMODE    = 16'h0001;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CTRL0,
    TGT_CTRL1,
    TGT_FLAGS,
    TGT_PMODE
  } target_e;

  typedef struct packed {
    target_e    tgt;
    logic       word;
    logic       upper;
  } access_t;
endpackage

// File: rtl/keyguard_decode.sv
module keyguard_decode
  import keyguard_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              word,
  output access_t           acc
);
  localparam int unsigned WA_W = ADDR_W - 1;

  logic [WA_W-1:0] word_addr;
  assign word_addr = addr[ADDR_W-1:1];

  always_comb begin
    acc.word  = word;
    acc.upper = ~word & addr[0];
    unique case (word_addr)
      WA_W'(OFS_CTRL0 >> 1): acc.tgt = TGT_CTRL0;
      WA_W'(OFS_CTRL1 >> 1): acc.tgt = TGT_CTRL1;
      WA_W'(OFS_FLAGS >> 1): acc.tgt = TGT_FLAGS;
      WA_W'(OFS_PMODE >> 1): acc.tgt = TGT_PMODE;
      default:               acc.tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/keyguard_policy.sv
module keyguard_policy
  import keyguard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  access_t           acc,
  input  logic [BYTE_W-1:0] key_byte,
  output logic              we_ctrl0_lo,
  output logic              we_ctrl1_lo,
  output logic [LANES-1:0]  we_flags,
  output logic [LANES-1:0]  we_pmode,
  output logic              open_q,
  output logic              rreq_q
);
  logic             live;
  logic             key_ok;
  logic             violation;
  logic             open_d;
  logic             rreq_d;
  logic [LANES-1:0] lane_en;

  assign live    = wr & ~rreq_q;
  assign key_ok  = (key_byte == UNLOCK_KEY);
  assign lane_en = acc.word ? {LANES{1'b1}} : (acc.upper ? 2'b10 : 2'b01);

  always_comb begin
    we_ctrl0_lo = 1'b0;
    we_ctrl1_lo = 1'b0;
    we_flags    = '0;
    we_pmode    = '0;
    violation   = 1'b0;
    open_d      = open_q;
    if (live) begin
      unique case (acc.tgt)
        TGT_CTRL0: begin
          if (acc.word) begin
            if (key_ok) begin
              open_d      = 1'b1;
              we_ctrl0_lo = 1'b1;
            end else begin
              violation = 1'b1;
            end
          end else if (acc.upper) begin
            open_d = key_ok;
          end else begin
            we_ctrl0_lo = open_q;
          end
        end
        TGT_CTRL1: begin
          if (!open_q)       violation   = 1'b1;
          else if (acc.word) we_ctrl1_lo = 1'b1;
        end
        TGT_FLAGS: begin
          if (!open_q) violation = 1'b1;
          else         we_flags  = lane_en;
        end
        TGT_PMODE: we_pmode = lane_en;
        default: ;
      endcase
    end
    if (rreq_q) open_d = 1'b0;
    rreq_d = live & violation;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      open_q <= open_d;
      rreq_q <= rreq_d;
    end
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> !rreq_q);

  a_r11_relock: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> !open_q);

  a_r4_bad_word_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rreq_q && acc.tgt == TGT_CTRL0 && acc.word && key_byte != UNLOCK_KEY)
      |=> rreq_q);

  a_r3_bad_byte_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rreq_q && acc.tgt == TGT_CTRL0 && acc.upper && key_byte != UNLOCK_KEY)
      |=> (!rreq_q && !open_q));

  a_r5_locked_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rreq_q && !open_q && (acc.tgt == TGT_CTRL1 || acc.tgt == TGT_FLAGS))
      |=> rreq_q);

  a_r6_pmode_free: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc.tgt == TGT_PMODE) |=> !rreq_q);
endmodule

// File: rtl/keyguard_store.sv
module keyguard_store
  import keyguard_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_ctrl0_lo,
  input  logic              we_ctrl1_lo,
  input  logic [LANES-1:0]  we_flags,
  input  logic [LANES-1:0]  we_pmode,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-2:0] rd_word,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned WA_W = ADDR_W - 1;

  logic [BYTE_W-1:0] ctrl0_lo;
  logic [BYTE_W-1:0] ctrl1_lo;
  logic [WORD_W-1:0] flags_q;
  logic [WORD_W-1:0] pmode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_lo <= INIT_CTRL0_LO;
      ctrl1_lo <= INIT_CTRL1_LO;
    end else begin
      if (we_ctrl0_lo) ctrl0_lo <= wdata[BYTE_W-1:0];
      if (we_ctrl1_lo) ctrl1_lo <= wdata[BYTE_W-1:0];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[g*BYTE_W +: BYTE_W] <= INIT_FLAGS[g*BYTE_W +: BYTE_W];
        pmode_q[g*BYTE_W +: BYTE_W] <= INIT_PMODE[g*BYTE_W +: BYTE_W];
      end else begin
        if (we_flags[g]) flags_q[g*BYTE_W +: BYTE_W] <= wdata[g*BYTE_W +: BYTE_W];
        if (we_pmode[g]) pmode_q[g*BYTE_W +: BYTE_W] <= wdata[g*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    unique case (rd_word)
      WA_W'(OFS_CTRL0 >> 1): rdata = {HI_READ, ctrl0_lo};
      WA_W'(OFS_CTRL1 >> 1): rdata = {HI_READ, ctrl1_lo};
      WA_W'(OFS_FLAGS >> 1): rdata = flags_q;
      WA_W'(OFS_PMODE >> 1): rdata = pmode_q;
      default:               rdata = '0;
    endcase
  end

  a_r10_pmode_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we_pmode == 2'b01) |=> (pmode_q[WORD_W-1:BYTE_W] == $past(pmode_q[WORD_W-1:BYTE_W])));
endmodule

// File: rtl/keyguard_regs.sv
module keyguard_regs
  import keyguard_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              write_open,
  output logic              reset_req
);
  access_t          acc;
  logic             we_ctrl0_lo;
  logic             we_ctrl1_lo;
  logic [LANES-1:0] we_flags;
  logic [LANES-1:0] we_pmode;

  keyguard_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .word (word),
    .acc  (acc)
  );

  keyguard_policy u_policy (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (wr),
    .acc         (acc),
    .key_byte    (wdata[WORD_W-1:BYTE_W]),
    .we_ctrl0_lo (we_ctrl0_lo),
    .we_ctrl1_lo (we_ctrl1_lo),
    .we_flags    (we_flags),
    .we_pmode    (we_pmode),
    .open_q      (write_open),
    .rreq_q      (reset_req)
  );

  keyguard_store #(.ADDR_W(ADDR_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_ctrl0_lo (we_ctrl0_lo),
    .we_ctrl1_lo (we_ctrl1_lo),
    .we_flags    (we_flags),
    .we_pmode    (we_pmode),
    .wdata       (wdata),
    .rd_word     (addr[ADDR_W-1:1]),
    .rdata       (rdata)
  );

  a_r7_ctrl1_byte_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !reset_req && write_open && !word && addr[ADDR_W-1:1] == (ADDR_W-1)'(OFS_CTRL1 >> 1))
      |=> (!reset_req && rdata == $past(rdata)));
endmodule

// File: tb/test_keyguard_regs.sv
module test_keyguard_regs;
  logic        clk;
  logic        rst_n;
  logic        wr;
  logic        word;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        write_open;
  logic        reset_req;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 0;

  logic [7:0]  m_c0, m_c1;
  logic [15:0] m_fl, m_pm;
  bit          m_open, m_rr;

  keyguard_regs i_keyguard_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr), .word(word), .addr(addr),
    .wdata(wdata), .rdata(rdata), .write_open(write_open), .reset_req(reset_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    case ({a[4:1], 1'b0})
      5'h00:   return {8'h96, m_c0};
      5'h02:   return {8'h96, m_c1};
      5'h0A:   return m_fl;
      5'h10:   return m_pm;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(input bit w, input bit wd, input logic [4:0] a, input logic [15:0] d);
    bit viol = 0;
    bit keyok = (d[15:8] == 8'hA5);
    bit up = !wd && a[0];
    if (m_rr) begin
      m_rr = 0;
      m_open = 0;
      return;
    end
    if (w) begin
      case ({a[4:1], 1'b0})
        5'h00: begin
          if (wd) begin
            if (keyok) begin m_open = 1; m_c0 = d[7:0]; end
            else viol = 1;
          end else if (up) m_open = keyok;
          else if (m_open) m_c0 = d[7:0];
        end
        5'h02: begin
          if (!m_open) viol = 1;
          else if (wd) m_c1 = d[7:0];
        end
        5'h0A: begin
          if (!m_open) viol = 1;
          else begin
            if (wd || up)  m_fl[15:8] = d[15:8];
            if (wd || !up) m_fl[7:0]  = d[7:0];
          end
        end
        5'h10: begin
          if (wd || up)  m_pm[15:8] = d[15:8];
          if (wd || !up) m_pm[7:0]  = d[7:0];
        end
        default: ;
      endcase
    end
    m_rr = viol;
  endtask

  task automatic step(input string tag, input bit w, input bit wd, input logic [4:0] a, input logic [15:0] d);
    wr = w; word = wd; addr = a; wdata = d;
    @(posedge clk);
    model_edge(w, wd, a, d);
    @(negedge clk);
    check(tag, "rdata", rdata, exp_rd(a));
    check(tag, "write_open", {15'd0, write_open}, {15'd0, m_open});
    check(tag, "reset_req", {15'd0, reset_req}, {15'd0, m_rr});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; wr = 0; word = 0; addr = '0; wdata = '0;
    m_c0 = 8'h40; m_c1 = 8'h00; m_fl = 16'h0000; m_pm = 16'h0001;
    m_open = 0; m_rr = 0;
    repeat (3) @(negedge clk);
    check("R1", "rdata", rdata, 16'h9640);
    check("R1", "write_open", {15'd0, write_open}, 16'd0);
    check("R1", "reset_req", {15'd0, reset_req}, 16'd0);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values, R12 unmapped reads zero
    step("R1", 0, 0, 5'h00, 16'h0);
    step("R1", 0, 0, 5'h03, 16'h0);
    step("R1", 0, 0, 5'h0A, 16'h0);
    step("R1", 0, 0, 5'h11, 16'h0);
    step("R12", 0, 0, 5'h06, 16'h0);
    // R5 locked guarded writes
    step("R5", 1, 1, 5'h0A, 16'h1234);
    step("R11", 0, 0, 5'h0A, 16'h0);
    step("R5", 1, 0, 5'h03, 16'h7700);
    step("R11", 0, 0, 5'h02, 16'h0);
    // R8 locked byte write to low control-0 is ignored
    step("R8", 1, 0, 5'h00, 16'h0033);
    // R2 byte key opens
    step("R2", 1, 0, 5'h01, 16'hA500);
    step("R8", 1, 0, 5'h00, 16'h0033);
    step("R9", 0, 0, 5'h01, 16'h0);
    // R7 control-1
    step("R7", 1, 1, 5'h02, 16'h127E);
    step("R7", 1, 0, 5'h02, 16'h0011);
    step("R7", 1, 0, 5'h03, 16'h2200);
    step("R9", 0, 0, 5'h02, 16'h0);
    // R10 byte lanes and word alignment on flags
    step("R10", 1, 0, 5'h0B, 16'hAB00);
    step("R10", 1, 0, 5'h0A, 16'h00CD);
    step("R10", 1, 1, 5'h0B, 16'h1234);
    step("R10", 1, 0, 5'h0A, 16'hFF5E);
    // R12 unmapped writes while open
    step("R12", 1, 1, 5'h06, 16'hFFFF);
    step("R12", 1, 0, 5'h1F, 16'hFF00);
    step("R12", 0, 0, 5'h1E, 16'h0);
    // R3 wrong byte key closes quietly
    step("R3", 1, 0, 5'h01, 16'h3C00);
    step("R3", 0, 0, 5'h00, 16'h0);
    // R6 power-mode while locked
    step("R6", 1, 1, 5'h10, 16'hBEEF);
    step("R6", 1, 0, 5'h11, 16'h5A00);
    step("R6", 1, 0, 5'h10, 16'h0042);
    // R4 wrong word key, R11 write during pulse ignored
    step("R2", 1, 1, 5'h00, 16'hA577);
    step("R4", 1, 1, 5'h00, 16'h1299);
    step("R11", 1, 0, 5'h01, 16'hA500);
    step("R11", 0, 0, 5'h00, 16'h0);
    step("R2", 1, 0, 5'h01, 16'hA500);
    step("R11", 1, 1, 5'h02, 16'h0000);
    step("R4", 1, 1, 5'h01, 16'h0055);
    step("R11", 1, 1, 5'h10, 16'h7777);
    step("R11", 0, 0, 5'h10, 16'h0);
    // R6 power-mode while open
    step("R2", 1, 1, 5'h00, 16'hA501);
    step("R6", 1, 1, 5'h11, 16'hC0DE);
    step("R5", 1, 1, 5'h0A, 16'h4321);
    step("R3", 1, 0, 5'h01, 16'hA400);
    step("R5", 1, 0, 5'h0B, 16'h9900);
    step("R11", 0, 0, 5'h0A, 16'h0);
    wr = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule